// File: doc/BRIEF.md
# Soft Mute Attenuation Ramp

This block applies a time-varying digital gain to a stereo stream of 24-bit signed PCM samples before conversion. A gain level between 0 (silence) and 255 (unity) is held internally. Raising the mute input drives the level down to zero one step at a time. Dropping it drives the level back up to the programmed attenuation code. Samples keep flowing through the block during the whole ramp, so a sample source can be swapped while the output is silent, without stopping the stream.

The level moves one step every N frame strobes, where N depends on the selected speed mode. A complete fade from code A therefore lasts A × N frames. If mute is withdrawn halfway down, the ramp turns around at once and climbs back over the same number of steps. When the attenuation code changes with mute inactive, the level walks to the new code at the same rate.

Top module: `soft_mute_ramp`

## Requirements
- R1: While `rst_n` is low at a clock edge, the gain level becomes 0 and both outputs become 0.
- R2: The level's target is 0 while `mute` is 1 and `atten_code` while `mute` is 0. The level moves toward its target and never passes it.
- R3: The level changes by exactly one per step. A step happens on the N-th frame strobe counted while the level differs from its target. N is 4 for `speed_sel`=0, 8 for 1, and 16 for 2 or 3.
- R4: While the level equals its target, the frame count is held at zero. A full fade from code 255 in normal speed therefore reaches level 0 on the 1020th strobe after `mute` rises.
- R5: If the target reverses partway through a ramp, the direction changes at the next step. The partial frame count is kept, so the return retraces the same number of steps.
- R6: Each output equals its channel's input multiplied by level/255. The multiply is signed and the quotient is truncated toward zero. The output is registered, one clock after the input and level it uses, and the two channels are scaled independently.
- R7: At level 0 both outputs are exactly 0. At level 255 each output equals its input.
- R8: Without a frame strobe the level holds. Samples are still scaled on every clock, whether or not a strobe is present.
- R9: If `atten_code` changes while `mute` is 0, the level steps toward the new code at the rate given in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_stb | input | 1 | One-clock pulse per stereo frame |
| mute | input | 1 | 1 fades to silence, 0 fades back to the attenuation code |
| atten_code | input | 8 | Programmed gain level, 0 to 255 (255 = unity) |
| speed_sel | input | 2 | Speed mode: 0 normal, 1 double, 2 or 3 quad |
| in_l | input | 24 | Left input sample, two's complement |
| in_r | input | 24 | Right input sample, two's complement |
| out_l | output | 24 | Scaled left sample |
| out_r | output | 24 | Scaled right sample |

## Verification
The hardest case to reach is a ramp reversal in which the step counter sits partway through a step period, combined with a change of speed mode while the ramp is running. The counter is invisible at the ports. The stimulus therefore cancels mute a few strobes into a step period and switches `speed_sel` mid-ramp. The bench's frame-accurate reference model then exposes any counter reset or off-by-one step as a gain error on the next samples. A separate phase feeds a constant full-scale sample and counts strobes until the output first reads zero. This checks the 1020-frame fade length directly at the ports.

// File: rtl/smr_pkg.sv
// Package: shared types and helpers for the soft mute ramp.
// Assumes speed modes are encoded on two bits, with code 3 treated as quad.
package smr_pkg;

    typedef enum logic [1:0] {
        SPD_NORMAL = 2'd0,
        SPD_DOUBLE = 2'd1,
        SPD_QUAD   = 2'd2,
        SPD_QUAD_X = 2'd3
    } speed_e;

    // Frames per gain step: the base count doubled once per speed mode, capped at quad.
    function automatic int unsigned frames_per_step(input speed_e spd, input int unsigned base);
        case (spd)
            SPD_NORMAL: return base;
            SPD_DOUBLE: return base * 2;
            default:    return base * 4;
        endcase
    endfunction

endpackage

// File: rtl/smr_step_timer.sv
// Step timer: counts frame strobes while a ramp is active and pulses `step`
// on the strobe that completes a step period. The count is held at zero while idle.
// Assumes a speed change mid-period takes effect at once (a count already past
// the new limit steps on the next strobe).
module smr_step_timer
    import smr_pkg::*;
#(
    parameter int unsigned BASE_FRAMES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_stb,
    input  logic       active,
    input  logic [1:0] speed_sel,
    output logic       step
);
    localparam int unsigned MAX_FRAMES = BASE_FRAMES * 4;
    localparam int unsigned CNT_W      = $clog2(MAX_FRAMES);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Terminal count of the current speed mode.
    always_comb begin
        limit = CNT_W'(frames_per_step(speed_e'(speed_sel), BASE_FRAMES) - 1);
        step  = active && frame_stb && (cnt_q >= limit);
    end

    // Frame counter: clear while idle or on a step, advance on each strobe otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || step) begin
            cnt_q <= '0;
        end else if (frame_stb) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/smr_level_ctrl.sv
// Level controller: holds the gain level and moves it one unit toward the
// target (0 when muted, else the attenuation code) on each step pulse.
// Assumes the target may change on any clock; the direction is re-evaluated per step.
module smr_level_ctrl #(
    parameter int unsigned LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mute,
    input  logic [LVL_W-1:0] atten_code,
    input  logic             step,
    output logic             active,
    output logic [LVL_W-1:0] level
);
    logic [LVL_W-1:0] target;

    // Target selection and ramp-active flag.
    always_comb begin
        target = mute ? '0 : atten_code;
        active = (level != target);
    end

    // Level register: one unit toward the target per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else if (step) begin
            if (level < target) begin
                level <= level + 1'b1;
            end else if (level > target) begin
                level <= level - 1'b1;
            end
        end
    end
endmodule

// File: rtl/smr_scaler.sv
// Channel scaler: registers sample * level / full_scale. The multiply is signed
// and the divide truncates toward zero. Assumes level never exceeds full scale.
module smr_scaler #(
    parameter int unsigned DATA_W = 24,
    parameter int unsigned LVL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample_in,
    input  logic [LVL_W-1:0]  level,
    output logic [DATA_W-1:0] sample_out
);
    localparam int unsigned PROD_W = DATA_W + LVL_W + 2;
    localparam int unsigned FULL   = (1 << LVL_W) - 1;

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] quo;

    // Signed product and division toward zero.
    always_comb begin
        prod = $signed({{(PROD_W-DATA_W){sample_in[DATA_W-1]}}, sample_in})
             * $signed({{(PROD_W-LVL_W){1'b0}}, level});
        quo  = prod / $signed(PROD_W'(FULL));
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_out <= '0;
        end else begin
            sample_out <= quo[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/soft_mute_ramp.sv
// Soft mute ramp top: a step timer, a level controller and one scaler per channel.
// Assumes frame_stb pulses for one clock per stereo frame and samples are valid every clock.
module soft_mute_ramp #(
    parameter int unsigned DATA_W      = 24,
    parameter int unsigned LVL_W       = 8,
    parameter int unsigned BASE_FRAMES = 4,
    parameter int unsigned CHANNELS    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic              mute,
    input  logic [LVL_W-1:0]  atten_code,
    input  logic [1:0]        speed_sel,
    input  logic [DATA_W-1:0] in_l,
    input  logic [DATA_W-1:0] in_r,
    output logic [DATA_W-1:0] out_l,
    output logic [DATA_W-1:0] out_r
);
    logic             step;
    logic             active;
    logic [LVL_W-1:0] level_q;
    logic [DATA_W-1:0] ch_in  [CHANNELS];
    logic [DATA_W-1:0] ch_out [CHANNELS];

    // Map the stereo ports onto the channel arrays.
    always_comb begin
        ch_in[0] = in_l;
        ch_in[1] = in_r;
        out_l    = ch_out[0];
        out_r    = ch_out[1];
    end

    smr_step_timer #(.BASE_FRAMES(BASE_FRAMES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .active    (active),
        .speed_sel (speed_sel),
        .step      (step)
    );

    smr_level_ctrl #(.LVL_W(LVL_W)) u_level (
        .clk        (clk),
        .rst_n      (rst_n),
        .mute       (mute),
        .atten_code (atten_code),
        .step       (step),
        .active     (active),
        .level      (level_q)
    );

    for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
        smr_scaler #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_scale (
            .clk        (clk),
            .rst_n      (rst_n),
            .sample_in  (ch_in[c]),
            .level      (level_q),
            .sample_out (ch_out[c])
        );
    end
endmodule

// File: rtl/smr_checker.sv
// Checker: temporal properties on the soft mute ramp, bound to the top module.
// Assumes it observes the internal gain level through the bind connection.
module smr_checker #(
    parameter int unsigned DATA_W = 24,
    parameter int unsigned LVL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic              mute,
    input  logic [LVL_W-1:0]  level,
    input  logic [DATA_W-1:0] in_l,
    input  logic [DATA_W-1:0] out_l,
    input  logic [DATA_W-1:0] out_r
);
    p_unit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (level == $past(level)) || (level == $past(level) + 1'b1) || (level == $past(level) - 1'b1));

    p_hold_no_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(level));

    p_silent_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |=> (out_l == '0) && (out_r == '0));

    p_unity_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (level == {LVL_W{1'b1}}) |=> (out_l == $past(in_l)));

    p_mute_no_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mute |=> (level <= $past(level)));

    p_sign_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (level != '0 && !in_l[DATA_W-1]) |=> !out_l[DATA_W-1]);
endmodule

bind soft_mute_ramp smr_checker #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_smr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_stb (frame_stb),
    .mute      (mute),
    .level     (level_q),
    .in_l      (in_l),
    .out_l     (out_l),
    .out_r     (out_r)
);

// File: tb/test_soft_mute_ramp.sv
module test_soft_mute_ramp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_stb = 1'b0;
    logic        mute = 1'b0;
    logic [7:0]  atten_code = 8'd0;
    logic [1:0]  speed_sel = 2'd0;
    logic [23:0] in_l = '0;
    logic [23:0] in_r = '0;
    logic [23:0] out_l;
    logic [23:0] out_r;

    soft_mute_ramp i_soft_mute_ramp (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .mute(mute),
        .atten_code(atten_code), .speed_sel(speed_sel),
        .in_l(in_l), .in_r(in_r), .out_l(out_l), .out_r(out_r)
    );

    always #4 clk = ~clk;

    int    vectors = 0;
    int    errors  = 0;
    int    cyc     = 0;
    int    strobes = 0;
    int    frame_gap = 4;
    bit    frames_on = 1'b1;
    bit    const_in  = 1'b0;
    bit    checking  = 1'b0;
    string req = "R1";
    logic [31:0] seed = 32'h1234_5678;

    // Behavioural reference model.
    int    m_lvl = 0;
    int    m_cnt = 0;
    logic [23:0] e_l = '0;
    logic [23:0] e_r = '0;

    function automatic logic [23:0] scale(input logic [23:0] x, input int lvl);
        longint p;
        p = longint'($signed(x)) * lvl;
        return 24'(p / 255);
    endfunction

    always @(posedge clk) begin
        int tgt;
        int n;
        if (!rst_n) begin
            m_lvl = 0; m_cnt = 0; e_l = '0; e_r = '0;
        end else begin
            e_l = scale(in_l, m_lvl);
            e_r = scale(in_r, m_lvl);
            tgt = mute ? 0 : int'(atten_code);
            n   = (speed_sel == 2'd0) ? 4 : (speed_sel == 2'd1) ? 8 : 16;
            if (m_lvl == tgt) begin
                m_cnt = 0;
            end else if (frame_stb) begin
                if (m_cnt >= n - 1) begin
                    m_cnt = 0;
                    m_lvl = (m_lvl < tgt) ? m_lvl + 1 : m_lvl - 1;
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
        end
    end

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    // One clock: compare at the negedge, then drive the next inputs.
    task automatic tick();
        @(negedge clk);
        if (checking) begin
            check({req, " left"},  out_l, e_l);
            check({req, " right"}, out_r, e_r);
        end
        cyc++;
        frame_stb = frames_on && (cyc % frame_gap == 0);
        if (frame_stb) strobes++;
        if (const_in) begin
            in_l = 24'h7FFFFF;
            in_r = 24'h800000;
        end else begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            in_l = seed[31:8];
            in_r = {seed[7:0], seed[31:16]};
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        int s0;
        // R1: reset state.
        run(3);
        check("R1 reset left", out_l, 24'h0);
        check("R1 reset right", out_r, 24'h0);
        checking = 1'b1;
        req = "R1";
        run(4);
        rst_n = 1'b1;
        // R2/R3: ramp up from 0 to 255 in normal speed.
        req = "R2 R3 ramp up";
        atten_code = 8'd255;
        run(4200);
        // R7: unity gain passes samples unchanged.
        req = "R7 unity";
        run(50);
        // R4: full fade length measured at the ports.
        req = "R4 fade";
        const_in = 1'b1;
        run(8);
        while (cyc % 4 != 3) tick();
        mute = 1'b1;
        s0 = strobes;
        begin
            int guard = 0;
            tick();
            while (out_l != 24'h0 && guard < 6000) begin tick(); guard++; end
        end
        check("R4 strobe count to silence", 24'(strobes - s0), 24'd1020);
        const_in = 1'b0;
        // R7: silence at level 0.
        req = "R7 silence";
        run(60);
        check("R7 zero left", out_l, 24'h0);
        // R5: partial fade then cancel mid-period, in double speed.
        req = "R5 reversal";
        mute = 1'b0;
        speed_sel = 2'd1;
        run(1500);
        mute = 1'b1;
        run(700);
        mute = 1'b0;
        run(1200);
        // R3: speed change in the middle of a ramp (quad, and code 3).
        req = "R3 speed";
        mute = 1'b1;
        run(333);
        speed_sel = 2'd2;
        run(900);
        speed_sel = 2'd3;
        run(900);
        mute = 1'b0;
        speed_sel = 2'd0;
        run(5000);
        // R9: attenuation code change without mute.
        req = "R9 code change";
        atten_code = 8'd100;
        run(2000);
        atten_code = 8'd140;
        run(1000);
        // R8: strobes stopped, level held, samples still scaled.
        req = "R8 no strobe";
        mute = 1'b1;
        run(37);
        frames_on = 1'b0;
        run(600);
        frames_on = 1'b1;
        frame_gap = 2;
        run(800);
        // R6: irregular strobe spacing with random samples.
        req = "R6 scaling";
        mute = 1'b0;
        frame_gap = 3;
        run(1500);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule